// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces RAM data addresses for a 16-bit signal-processing core. It holds four pointer registers and four support registers: a step, a wrap start, a wrap limit and a page base. It issues one access per cycle on a valid / write-flag / address output. The memory array is outside the block, so the output stands in for the RAM strobe.

Three kinds of access are supported. An indirect access issues a pointer and then post-modifies it. A compound access reads and then writes one pointer location over two consecutive cycles. A direct access joins the upper bits of the page base with a 5-bit offset taken from the instruction. On indirect and compound accesses, the unmodified pointer is compared with the wrap limit. In the modes that take part in wrapping, a match reloads the pointer from the wrap start instead of incrementing it. Two compound modes never wrap. A 16-bit load port writes any of the eight registers, and a load to a pointer takes priority over a post-modification of that pointer in the same cycle.

Top module: `dsp_addr_gen`

## Requirements
- R1: While reset is low, and after it is released, memValid is 0 and all eight registers hold zero.
- R2: A direct access (cmdKind 2) drives memAddr = {page base bits 15..5, cmdOffset}. Bits 4..0 of the value loaded into the page base (regWrSel 7) have no effect on the address.
- R3: During a direct access, dirReg repeats cmdReg. dirIsPtr is 1 for codes 0..3, which are the pointers, and 0 for codes 4..15, where 4..7 are the high and low halves of the two accumulators. Both outputs are 0 on other accesses.
- R4: An indirect access (cmdKind 0) shows its result on the outputs one cycle after the command is sampled: memValid 1, memWrite = cmdWrite, memAddr = the unmodified pointer. The pointer then holds for cmdMode 0, adds 1 for mode 1, subtracts 1 for mode 2 and adds the step register for mode 3.
- R5: In indirect mode 1, if the pointer equals the wrap limit, the pointer is loaded from the wrap start instead of being incremented.
- R6: A compound access (cmdKind 1) produces two consecutive output cycles: a read, then a write, both at the pointer value held when the command was sampled.
- R7: Compound mode 0 adds 1 to the pointer after the read cycle and leaves it unchanged after the write. A match with the wrap limit in the read cycle reloads the wrap start instead.
- R8: Compound mode 1 leaves the pointer unchanged after the read and adds 1 after the write. A match with the wrap limit in the write cycle reloads the wrap start instead.
- R9: Compound mode 2 subtracts 2 after the read, and compound mode 3 adds the step register after the write. Neither reloads on a wrap-limit match.
- R10: regWrSel codes are 0..3 for the pointers, 4 for the wrap start, 5 for the wrap limit, 6 for the step and 7 for the page base. A load to a pointer in the same cycle as that pointer's post-modification wins.
- R11: A command presented in the cycle that the write half of a compound access takes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdKind | input | 2 | 0 indirect, 1 compound, 2 direct, 3 none |
| cmdWrite | input | 1 | Write direction for indirect and direct accesses |
| cmdPtr | input | PTR_W (2) | Pointer selected |
| cmdMode | input | 2 | Post-modification mode |
| cmdOffset | input | OFF_W (5) | Direct offset inside the page |
| cmdReg | input | 4 | Direct source/destination register code |
| regWrEn | input | 1 | Register load strobe |
| regWrSel | input | WSEL_W (3) | Register selected for loading |
| regWrData | input | AW (16) | Load value |
| memValid | output | 1 | Access issued |
| memWrite | output | 1 | 1 write, 0 read |
| memAddr | output | AW (16) | RAM address |
| dirReg | output | 4 | Register code of a direct access |
| dirIsPtr | output | 1 | Direct register code names a pointer |

## Verification
The bench places a pointer exactly on the wrap limit in every mode. A design that wraps in the wrong cycle of a compound access, or that wraps in the exempt decrement-by-two and add-step modes, leaves a pointer value that the next indirect access exposes on memAddr. It also tests a wrap that is added on top of the increment instead of replacing it. Further cases cover:
- a pointer load that collides with a post-increment, which catches the wrong priority;
- a command during a compound write cycle, which catches a controller that accepts it;
- a page base with non-zero low bits, which catches address bits leaking into the direct address.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    KIND_IND  = 2'd0,
    KIND_CMP  = 2'd1,
    KIND_DIR  = 2'd2,
    KIND_NONE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    MOD_HOLD = 3'd0,
    MOD_INC  = 3'd1,
    MOD_DEC  = 3'd2,
    MOD_STEP = 3'd3,
    MOD_DEC2 = 3'd4
  } mod_e;

  // strobes from control to datapath for the access in the current cycle
  typedef struct packed {
    logic issue;
    logic isWrite;
    logic useDirect;
    logic useSaved;
    logic cmpRead;
    logic wrapOk;
    mod_e modOp;
  } strobe_t;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
#(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic             cmdWrite,
  input  logic [PTR_W-1:0] cmdPtr,
  input  logic [1:0]       cmdMode,
  output strobe_t          st,
  output logic [PTR_W-1:0] actPtr
);

  logic             phaseWr;
  logic [PTR_W-1:0] heldPtr;
  logic [1:0]       heldMode;
  logic             startCmp;

  assign startCmp = !phaseWr && cmdValid && (kind_e'(cmdKind) == KIND_CMP);

  always_comb begin
    st     = '0;
    actPtr = cmdPtr;
    if (phaseWr) begin
      st.issue    = 1'b1;
      st.isWrite  = 1'b1;
      st.useSaved = 1'b1;
      actPtr      = heldPtr;
      case (heldMode)
        2'd1: begin st.modOp = MOD_INC; st.wrapOk = 1'b1; end
        2'd3: st.modOp = MOD_STEP;
        default: st.modOp = MOD_HOLD;
      endcase
    end else if (cmdValid) begin
      case (kind_e'(cmdKind))
        KIND_IND: begin
          st.issue   = 1'b1;
          st.isWrite = cmdWrite;
          case (cmdMode)
            2'd1: begin st.modOp = MOD_INC; st.wrapOk = 1'b1; end
            2'd2: st.modOp = MOD_DEC;
            2'd3: st.modOp = MOD_STEP;
            default: st.modOp = MOD_HOLD;
          endcase
        end
        KIND_CMP: begin
          st.issue   = 1'b1;
          st.cmpRead = 1'b1;
          case (cmdMode)
            2'd0: begin st.modOp = MOD_INC; st.wrapOk = 1'b1; end
            2'd2: st.modOp = MOD_DEC2;
            default: st.modOp = MOD_HOLD;
          endcase
        end
        KIND_DIR: begin
          st.issue     = 1'b1;
          st.isWrite   = cmdWrite;
          st.useDirect = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseWr  <= 1'b0;
      heldPtr  <= '0;
      heldMode <= '0;
    end else begin
      phaseWr <= startCmp;
      if (startCmp) begin
        heldPtr  <= cmdPtr;
        heldMode <= cmdMode;
      end
    end
  end

  // R11: a write cycle is never followed by a second write cycle
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    phaseWr |=> !phaseWr);

endmodule

// File: rtl/dag_dpath.sv
module dag_dpath
  import dag_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NPTR   = 4,
  parameter int OFF_W  = 5,
  parameter int DR_W   = 4,
  parameter int PTR_W  = $clog2(NPTR),
  parameter int WSEL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [PTR_W-1:0]  actPtr,
  input  logic [OFF_W-1:0]  cmdOffset,
  input  logic [DR_W-1:0]   cmdReg,
  input  logic              regWrEn,
  input  logic [WSEL_W-1:0] regWrSel,
  input  logic [AW-1:0]     regWrData,
  output logic              memValid,
  output logic              memWrite,
  output logic [AW-1:0]     memAddr,
  output logic [DR_W-1:0]   dirReg,
  output logic              dirIsPtr
);

  localparam int PAGE_W = AW - OFF_W;
  localparam logic [WSEL_W-1:0] SEL_BEGIN = WSEL_W'(NPTR);
  localparam logic [WSEL_W-1:0] SEL_END   = WSEL_W'(NPTR + 1);
  localparam logic [WSEL_W-1:0] SEL_STEP  = WSEL_W'(NPTR + 2);
  localparam logic [WSEL_W-1:0] SEL_PAGE  = WSEL_W'(NPTR + 3);

  logic [AW-1:0]     ptrQ [NPTR];
  logic [AW-1:0]     beginQ, endQ, stepQ, savedQ;
  logic [PAGE_W-1:0] pageQ;
  logic [AW-1:0]     curPtr, modVal, nextPtr, addrNext;
  logic              modHit, wrapHit, cmpRdQ, ptrLoadHit;

  assign curPtr     = ptrQ[actPtr];
  assign modHit     = st.issue && !st.useDirect && (st.modOp != MOD_HOLD);
  assign wrapHit    = st.wrapOk && (curPtr == endQ);
  assign ptrLoadHit = regWrEn && (regWrSel == {1'b0, actPtr});

  always_comb begin
    case (st.modOp)
      MOD_INC:  modVal = curPtr + AW'(1);
      MOD_DEC:  modVal = curPtr - AW'(1);
      MOD_STEP: modVal = curPtr + stepQ;
      MOD_DEC2: modVal = curPtr - AW'(2);
      default:  modVal = curPtr;
    endcase
    nextPtr = wrapHit ? beginQ : modVal;
  end

  always_comb begin
    if (st.useDirect)     addrNext = {pageQ, cmdOffset};
    else if (st.useSaved) addrNext = savedQ;
    else                  addrNext = curPtr;
  end

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ[i] <= '0;
      else if (regWrEn && regWrSel == WSEL_W'(i))
        ptrQ[i] <= regWrData;
      else if (modHit && actPtr == PTR_W'(i))
        ptrQ[i] <= nextPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beginQ <= '0;
      endQ   <= '0;
      stepQ  <= '0;
      pageQ  <= '0;
    end else if (regWrEn) begin
      case (regWrSel)
        SEL_BEGIN: beginQ <= regWrData;
        SEL_END:   endQ   <= regWrData;
        SEL_STEP:  stepQ  <= regWrData;
        SEL_PAGE:  pageQ  <= regWrData[AW-1:OFF_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedQ   <= '0;
      memValid <= 1'b0;
      memWrite <= 1'b0;
      memAddr  <= '0;
      dirReg   <= '0;
      dirIsPtr <= 1'b0;
      cmpRdQ   <= 1'b0;
    end else begin
      if (st.issue && !st.useSaved && !st.useDirect) savedQ <= curPtr;
      memValid <= st.issue;
      memWrite <= st.issue && st.isWrite;
      memAddr  <= st.issue ? addrNext : '0;
      dirReg   <= (st.issue && st.useDirect) ? cmdReg : '0;
      dirIsPtr <= st.issue && st.useDirect && (32'(cmdReg) < NPTR);
      cmpRdQ   <= st.issue && st.cmpRead;
    end
  end

  // R6: the read half of a compound access is followed by a write at the same address
  assert_cmp_same_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmpRdQ |=> (memValid && memWrite && memAddr == $past(memAddr)));

  // R2: the upper address bits of a direct access come from the page base
  assert_direct_page_R2: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && st.useDirect) |=> (memAddr[AW-1:OFF_W] == $past(pageQ)));

  // R5, R7, R8: a match in a wrap mode reloads the wrap start
  assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modHit && wrapHit && !ptrLoadHit) |=> (ptrQ[$past(actPtr)] == $past(beginQ)));

  // R9: decrement-by-two ignores a wrap-limit match
  assert_dec2_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modHit && st.modOp == MOD_DEC2 && curPtr == endQ && !ptrLoadHit)
      |=> (ptrQ[$past(actPtr)] == $past(endQ) - AW'(2)));

  // R10: a pointer load wins over a simultaneous post-modification
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrSel < SEL_BEGIN)
      |=> (ptrQ[$past(regWrSel[PTR_W-1:0])] == $past(regWrData)));

endmodule

// File: rtl/dsp_addr_gen.sv
module dsp_addr_gen
  import dag_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NPTR   = 4,
  parameter int OFF_W  = 5,
  parameter int DR_W   = 4,
  parameter int PTR_W  = $clog2(NPTR),
  parameter int WSEL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdKind,
  input  logic              cmdWrite,
  input  logic [PTR_W-1:0]  cmdPtr,
  input  logic [1:0]        cmdMode,
  input  logic [OFF_W-1:0]  cmdOffset,
  input  logic [DR_W-1:0]   cmdReg,
  input  logic              regWrEn,
  input  logic [WSEL_W-1:0] regWrSel,
  input  logic [AW-1:0]     regWrData,
  output logic              memValid,
  output logic              memWrite,
  output logic [AW-1:0]     memAddr,
  output logic [DR_W-1:0]   dirReg,
  output logic              dirIsPtr
);

  strobe_t          st;
  logic [PTR_W-1:0] actPtr;

  dag_ctrl #(.PTR_W(PTR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdWrite(cmdWrite), .cmdPtr(cmdPtr), .cmdMode(cmdMode),
    .st(st), .actPtr(actPtr)
  );

  dag_dpath #(.AW(AW), .NPTR(NPTR), .OFF_W(OFF_W), .DR_W(DR_W),
              .PTR_W(PTR_W), .WSEL_W(WSEL_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .actPtr(actPtr),
    .cmdOffset(cmdOffset), .cmdReg(cmdReg),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .dirReg(dirReg), .dirIsPtr(dirIsPtr)
  );

endmodule

// File: tb/sim_dsp_addr_gen.sv
module sim_dsp_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd3;
  logic        cmdWrite = 1'b0;
  logic [1:0]  cmdPtr = '0;
  logic [1:0]  cmdMode = '0;
  logic [4:0]  cmdOffset = '0;
  logic [3:0]  cmdReg = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [15:0] regWrData = '0;
  logic        memValid, memWrite, dirIsPtr;
  logic [15:0] memAddr;
  logic [3:0]  dirReg;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dsp_addr_gen u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdWrite(cmdWrite), .cmdPtr(cmdPtr), .cmdMode(cmdMode),
    .cmdOffset(cmdOffset), .cmdReg(cmdReg), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .dirReg(dirReg), .dirIsPtr(dirIsPtr)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        we;
    logic [2:0]  ws;
    logic [15:0] wd;
    logic        cv;
    logic [1:0]  k;
    logic        w;
    logic [1:0]  p;
    logic [1:0]  m;
    logic [4:0]  off;
    logic [3:0]  dr;
    logic        eV;
    logic        eW;
    logic [15:0] eA;
    logic [3:0]  eDr;
    logic        eDp;
  } vec_t;

  // kinds: 0 indirect, 1 compound, 2 direct; load codes 0..3 ptr, 4 start, 5 limit, 6 step, 7 page
  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{"R10",1,0,16'h0010,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R10",1,5,16'h0012,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R10",1,4,16'h0008,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R10",1,6,16'h0005,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R10",1,7,16'hABCD,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R4 ",0,0,16'h0000,1,0,0,0,1,0,0, 1,0,16'h0010,0,0},   // R4 read, +1
    '{"R4 ",0,0,16'h0000,1,0,1,0,1,0,0, 1,1,16'h0011,0,0},   // R4 write, +1
    '{"R5 ",0,0,16'h0000,1,0,0,0,1,0,0, 1,0,16'h0012,0,0},   // R5 at limit: reload
    '{"R5 ",0,0,16'h0000,1,0,0,0,3,0,0, 1,0,16'h0008,0,0},   // R5 reloaded value, then +step
    '{"R4 ",0,0,16'h0000,1,0,0,0,2,0,0, 1,0,16'h000D,0,0},   // R4 step result, then -1
    '{"R4 ",0,0,16'h0000,1,0,0,0,0,0,0, 1,0,16'h000C,0,0},   // R4 hold
    '{"R4 ",0,0,16'h0000,1,0,0,0,0,0,0, 1,0,16'h000C,0,0},
    '{"R2 ",0,0,16'h0000,1,2,0,0,0,5'h13,4'h6, 1,0,16'hABD3,4'h6,0},  // R2 R3
    '{"R3 ",0,0,16'h0000,1,2,1,0,0,5'h1F,4'h2, 1,1,16'hABDF,4'h2,1},  // R3 pointer code
    '{"R10",1,1,16'h0020,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R10",1,5,16'h0020,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R7 ",0,0,16'h0000,1,1,0,1,0,0,0, 1,0,16'h0020,0,0},   // R6 R7 read half
    '{"R11",0,0,16'h0000,1,0,0,0,1,0,0, 1,1,16'h0020,0,0},   // R6 write half, command ignored
    '{"R7 ",0,0,16'h0000,1,0,0,1,0,0,0, 1,0,16'h0008,0,0},   // R7 wrapped in read cycle
    '{"R11",0,0,16'h0000,1,0,0,0,0,0,0, 1,0,16'h000C,0,0},   // R11 ptr0 untouched
    '{"R10",1,2,16'h0020,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R8 ",0,0,16'h0000,1,1,0,2,1,0,0, 1,0,16'h0020,0,0},   // R8 read half
    '{"R8 ",0,0,16'h0000,0,0,0,0,0,0,0, 1,1,16'h0020,0,0},   // R8 write half
    '{"R8 ",0,0,16'h0000,1,0,0,2,0,0,0, 1,0,16'h0008,0,0},   // R8 wrapped in write cycle
    '{"R10",1,3,16'h0030,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R8 ",0,0,16'h0000,1,1,0,3,1,0,0, 1,0,16'h0030,0,0},
    '{"R8 ",0,0,16'h0000,0,0,0,0,0,0,0, 1,1,16'h0030,0,0},
    '{"R8 ",0,0,16'h0000,1,0,0,3,0,0,0, 1,0,16'h0031,0,0},   // R8 plain +1 after write
    '{"R10",1,3,16'h0020,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R9 ",0,0,16'h0000,1,1,0,3,2,0,0, 1,0,16'h0020,0,0},
    '{"R9 ",0,0,16'h0000,0,0,0,0,0,0,0, 1,1,16'h0020,0,0},
    '{"R9 ",0,0,16'h0000,1,0,0,3,0,0,0, 1,0,16'h001E,0,0},   // R9 -2, no wrap
    '{"R10",1,2,16'h0020,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R9 ",0,0,16'h0000,1,1,0,2,3,0,0, 1,0,16'h0020,0,0},
    '{"R9 ",0,0,16'h0000,0,0,0,0,0,0,0, 1,1,16'h0020,0,0},
    '{"R9 ",0,0,16'h0000,1,0,0,2,0,0,0, 1,0,16'h0025,0,0},   // R9 +step, no wrap
    '{"R10",1,0,16'h0100,1,0,0,0,1,0,0, 1,0,16'h000C,0,0},   // R10 load collides with +1
    '{"R10",0,0,16'h0000,1,0,0,0,0,0,0, 1,0,16'h0100,0,0},   // R10 load won
    '{"R2 ",1,7,16'hABDF,0,0,0,0,0,0,0, 0,0,16'h0000,0,0},
    '{"R2 ",0,0,16'h0000,1,2,0,0,0,5'h00,4'hF, 1,0,16'hABC0,4'hF,0}  // R2 low page bits ignored
  };

  task automatic check(input string req, input logic eV, input logic eW,
                       input logic [15:0] eA, input logic [3:0] eDr, input logic eDp);
    total++;
    if (memValid !== eV || (eV && (memWrite !== eW || memAddr !== eA ||
        dirReg !== eDr || dirIsPtr !== eDp))) begin
      bad++;
      $display("FAIL %s: got v=%0b w=%0b a=%h dr=%h dp=%0b expected v=%0b w=%0b a=%h dr=%h dp=%0b",
               req, memValid, memWrite, memAddr, dirReg, dirIsPtr, eV, eW, eA, eDr, eDp);
    end
  endtask

  task automatic idle();
    cmdValid = 1'b0; cmdKind = 2'd3; regWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      regWrEn = VECS[i].we; regWrSel = VECS[i].ws; regWrData = VECS[i].wd;
      cmdValid = VECS[i].cv; cmdKind = VECS[i].k; cmdWrite = VECS[i].w;
      cmdPtr = VECS[i].p; cmdMode = VECS[i].m; cmdOffset = VECS[i].off;
      cmdReg = VECS[i].dr;
      @(posedge clk);
      #1 check(string'(VECS[i].tag), VECS[i].eV, VECS[i].eW, VECS[i].eA,
               VECS[i].eDr, VECS[i].eDp);
      @(negedge clk);
    end

    // R4: an idle cycle drops the strobe
    idle();
    @(posedge clk);
    #1 check("R4", 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);

    // R1: reset mid-run clears pointers and page base
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 check("R1", 1'b0, 1'b0, 16'h0, 4'h0, 1'b0);
    @(negedge clk) rstN = 1'b1;
    cmdValid = 1'b1; cmdKind = 2'd0; cmdWrite = 1'b0; cmdPtr = 2'd3; cmdMode = 2'd0;
    @(posedge clk);
    #1 check("R1", 1'b1, 1'b0, 16'h0000, 4'h0, 1'b0);
    @(negedge clk);
    cmdKind = 2'd2; cmdOffset = 5'h05; cmdReg = 4'h4;
    @(posedge clk);
    #1 check("R1", 1'b1, 1'b0, 16'h0005, 4'h4, 1'b0);
    @(negedge clk) idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule